// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is an up-counter built from a chain of identical counter stages. Each stage is a small binary register. It has an active-low asynchronous clear, an active-low synchronous preset from a data word, and two count enables. A stage counts only when both enables are high. Only the second enable, the carry-in enable, reaches the stage's carry-out flag. That flag goes high when the carry-in enable is high and the stage holds all ones.

The top module chains `STAGES` stages of `WIDTH` bits each:
- The free-running enable and the preset strobe are shared by every stage.
- Each stage's carry-out drives the carry-in enable of the stage above it.
- The carry-out of the last stage becomes the block's terminal-count output.

As a result, the concatenated outputs act as one counter of `STAGES*WIDTH` bits. A system uses it as a settable event or cycle counter. The terminal-count output can feed a further counter outside the block.

Top module: `chain_counter`

## Requirements
- R1: While `clearN` is low, `count` is zero, whatever the other inputs do. The clear takes effect as soon as `clearN` falls, with no clock edge needed. A rising clock edge during clear, even with `loadN` low, leaves `count` at zero.
- R2: On a rising clock edge with `loadN` low, `count` takes the value of `loadData` (bit i of `loadData` goes to bit i of `count`). This holds whatever the levels of `enP` and `enT`.
- R3: On a rising clock edge with `loadN` high and both `enP` and `enT` high, `count` increases by one.
- R4: On a rising clock edge with `loadN` high and either `enP` or `enT` low, `count` keeps its value.
- R5: `termCount` is high exactly when `enT` is high and every bit of `count` is one. It follows `enT` with no clock edge in between.
- R6: While `clearN` is low, `termCount` is low, even with `enT` high.
- R7: Counting up from the all-ones value gives zero on the next edge, and counting continues from there.
- R8: Stage k (bits `k*WIDTH` upward) advances only on an edge where every lower stage holds all ones. The whole output therefore behaves as a single `STAGES*WIDTH`-bit counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clearN | input | 1 | Asynchronous clear, active low |
| loadN | input | 1 | Synchronous preset strobe, active low |
| loadData | input | STAGES*WIDTH | Preset value |
| enP | input | 1 | Count enable shared by all stages |
| enT | input | 1 | Carry-in enable of the lowest stage; also gates `termCount` |
| count | output | STAGES*WIDTH | Counter value |
| termCount | output | 1 | High when `enT` is high and `count` is all ones |

## Verification
The bench builds the block with `WIDTH` = 4 and `STAGES` = 2, giving an 8-bit counter from two chained stages. With this setting, a preset of 0xFC followed by counting walks through the all-ones value and wraps to zero. A preset just below a nibble boundary then shows the carry crossing from the lower stage into the upper one. A reference model tracks every cycle. Clear is applied between clock edges, so the asynchronous zeroing is seen before the next edge.

// File: rtl/chain_counter_pkg.sv
package chain_counter_pkg;
  // Strobes passed from a stage's control to its datapath
  typedef struct packed {
    logic load;     // capture preset word on the next edge
    logic advance;  // increment on the next edge
  } stage_strobe_t;
endpackage

// File: rtl/counter_stage_ctrl.sv
module counter_stage_ctrl
  import chain_counter_pkg::*;
(
  input  logic          loadN,
  input  logic          enP,
  input  logic          enT,
  input  logic          allOnes,
  output stage_strobe_t strobes,
  output logic          carryOut
);
  always_comb begin
    strobes.load    = !loadN;
    strobes.advance = loadN && enP && enT;
    carryOut        = enT && allOnes;
  end
endmodule

// File: rtl/counter_stage_dp.sv
module counter_stage_dp
  import chain_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearN,
  input  stage_strobe_t    strobes,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] count,
  output logic             allOnes
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk or negedge clearN) begin
    if (!clearN)
      count <= '0;
    else if (strobes.load)
      count <= loadData;
    else if (strobes.advance)
      count <= count + ONE;
  end

  assign allOnes = &count;
endmodule

// File: rtl/counter_stage.sv
module counter_stage
  import chain_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             loadN,
  input  logic [WIDTH-1:0] loadData,
  input  logic             enP,
  input  logic             enT,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);
  stage_strobe_t strobes;
  logic          allOnes;

  counter_stage_ctrl u_ctrl (
    .loadN    (loadN),
    .enP      (enP),
    .enT      (enT),
    .allOnes  (allOnes),
    .strobes  (strobes),
    .carryOut (carryOut)
  );

  counter_stage_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .clearN   (clearN),
    .strobes  (strobes),
    .loadData (loadData),
    .count    (count),
    .allOnes  (allOnes)
  );
endmodule

// File: rtl/chain_counter.sv
module chain_counter #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic                     clk,
  input  logic                     clearN,
  input  logic                     loadN,
  input  logic [STAGES*WIDTH-1:0]  loadData,
  input  logic                     enP,
  input  logic                     enT,
  output logic [STAGES*WIDTH-1:0]  count,
  output logic                     termCount
);
  // carry[k] is the carry-in enable of stage k
  logic [STAGES:0] carry;

  assign carry[0] = enT;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    counter_stage #(.WIDTH(WIDTH)) u_stage (
      .clk      (clk),
      .clearN   (clearN),
      .loadN    (loadN),
      .loadData (loadData[k*WIDTH +: WIDTH]),
      .enP      (enP),
      .enT      (carry[k]),
      .count    (count[k*WIDTH +: WIDTH]),
      .carryOut (carry[k+1])
    );
  end

  assign termCount = carry[STAGES];
endmodule

// File: rtl/chain_counter_chk.sv
module chain_counter_chk #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input logic                    clk,
  input logic                    clearN,
  input logic                    loadN,
  input logic [STAGES*WIDTH-1:0] loadData,
  input logic                    enP,
  input logic                    enT,
  input logic [STAGES*WIDTH-1:0] count,
  input logic                    termCount
);
  localparam int TW = STAGES * WIDTH;

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!clearN)
    !loadN |=> count == $past(loadData));

  // R3
  advance_by_one_chk: assert property (@(posedge clk) disable iff (!clearN)
    (loadN && enP && enT) |=> (count - $past(count)) == TW'(1));

  // R4
  hold_value_chk: assert property (@(posedge clk) disable iff (!clearN)
    (loadN && !(enP && enT)) |=> $stable(count));

  // R5
  term_count_chk: assert property (@(posedge clk) disable iff (!clearN)
    termCount == (enT && (&count)));
endmodule

bind chain_counter chain_counter_chk #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chk (
  .clk       (clk),
  .clearN    (clearN),
  .loadN     (loadN),
  .loadData  (loadData),
  .enP       (enP),
  .enT       (enT),
  .count     (count),
  .termCount (termCount)
);

// File: tb/chain_counter_bench.sv
`timescale 1ns/1ps
module chain_counter_bench;
  localparam int WIDTH  = 4;
  localparam int STAGES = 2;
  localparam int TW     = STAGES * WIDTH;
  localparam logic [TW-1:0] MAXV = '1;

  logic          clk = 1'b0;
  logic          clearN = 1'b0;
  logic          loadN = 1'b1;
  logic [TW-1:0] loadData = '0;
  logic          enP = 1'b0;
  logic          enT = 1'b0;
  logic [TW-1:0] count;
  logic          termCount;

  int            nRun = 0;
  int            nFail = 0;
  logic [TW-1:0] model = '0;
  bit            finished = 1'b0;

  always #2 clk = ~clk;

  chain_counter #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chain_counter (
    .clk(clk), .clearN(clearN), .loadN(loadN), .loadData(loadData),
    .enP(enP), .enT(enT), .count(count), .termCount(termCount)
  );

  task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Inputs are driven one ns after a rising edge; results are sampled one ns after the next.
  task automatic step(input logic ld, input logic ep, input logic et,
                      input logic [TW-1:0] d, input string req);
    loadN = ld; enP = ep; enT = et; loadData = d;
    #1;
    check({req, " R5 tc before edge"}, TW'(termCount), TW'(et && (model == MAXV)));
    @(posedge clk);
    if (!ld) model = d;
    else if (ep && et) model = model + TW'(1);
    #1;
    check({req, " count"}, count, model);
    check({req, " R5 tc"}, TW'(termCount), TW'(et && (model == MAXV)));
  endtask

  task automatic t_reset;
    clearN = 1'b0; enT = 1'b1; enP = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset count", count, '0);
    check("R6 reset tc", TW'(termCount), '0);
    clearN = 1'b1;
    model = '0;
  endtask

  task automatic t_sequence;
    step(1'b0, 1'b0, 1'b0, 8'hFC, "R2 preset");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b1, 8'h00, "R3 count");
    check("R7 wrap lands at two", count, 8'h02);
  endtask

  task automatic t_hold;
    step(1'b1, 1'b0, 1'b1, 8'hAA, "R4 enP low");
    step(1'b1, 1'b1, 1'b0, 8'hAA, "R4 enT low");
    step(1'b1, 1'b0, 1'b0, 8'hAA, "R4 both low");
    check("R4 held value", count, 8'h02);
  endtask

  task automatic t_load_priority;
    step(1'b0, 1'b1, 1'b1, 8'h5A, "R2 load over enables");
    check("R2 loaded word", count, 8'h5A);
    step(1'b0, 1'b0, 1'b0, 8'hA5, "R2 load enables low");
  endtask

  task automatic t_cascade;
    step(1'b0, 1'b0, 1'b0, 8'h0E, "R8 preset");
    step(1'b1, 1'b1, 1'b1, 8'h00, "R8 low nibble only");
    check("R8 upper stage still", TW'(count[7:4]), TW'(0));
    step(1'b1, 1'b1, 1'b1, 8'h00, "R8 carry crosses");
    check("R8 upper stage stepped", TW'(count[7:4]), TW'(1));
    step(1'b1, 1'b1, 1'b1, 8'h00, "R8 after carry");
    check("R8 upper stage holds", TW'(count[7:4]), TW'(1));
  endtask

  task automatic t_tc_comb;
    step(1'b0, 1'b0, 1'b1, 8'hFF, "R5 preset all ones");
    loadN = 1'b1; enP = 1'b0;
    enT = 1'b0; #0.5;
    check("R5 tc drops with enT", TW'(termCount), '0);
    enT = 1'b1; #0.5;
    check("R5 tc rises with enT", TW'(termCount), TW'(1));
    @(posedge clk); #1;
    check("R4 count held at max", count, MAXV);
  endtask

  task automatic t_clear_midcycle;
    loadN = 1'b1; enP = 1'b1; enT = 1'b1;
    #0.5;
    clearN = 1'b0;
    #0.5;
    check("R1 clear before edge", count, '0);
    check("R6 tc low in clear", TW'(termCount), '0);
    loadN = 1'b0; loadData = 8'hC3;
    @(posedge clk); #1;
    check("R1 load ignored in clear", count, '0);
    clearN = 1'b1;
    model = '0;
    step(1'b1, 1'b1, 1'b1, 8'h00, "R3 after clear");
  endtask

  initial begin
    t_reset();
    @(posedge clk); #1;
    t_sequence();
    t_hold();
    t_load_priority();
    t_cascade();
    t_tc_comb();
    t_clear_midcycle();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule